// File: doc/BRIEF.md
# MIDI Serial Port with Double-Buffered Transmitter

This block is a byte-wide asynchronous serial port for a MIDI link. A CPU sees it as two byte locations. The first location reads back a status byte and takes writes to a control byte. The second location reads the most recently received byte and takes writes of the next byte to send. Every frame carries one low start bit, eight data bits sent least significant first, and one high stop bit. At the default setting each bit lasts 256 clocks, which is 31250 bit/s from an 8 MHz clock.

The transmitter has two stages. A holding register accepts a byte from the CPU. A shift register puts frames on the line back to back. The transmit-empty flag tells software when it may write again. The flag clears on a data write and sets one bit time after the byte moves from the holding register into the shift register. If a frame is still on the line, that move waits until the frame ends. The receiver samples each bit at its centre and writes the finished byte into a one-byte receive register. An active-low interrupt line combines a receive cause and a transmit cause, each enabled by a control-bit pattern.

Top module: `midi_serial_port`

## Requirements
- R1: After reset the control byte is 0x00, a status read returns 0x02, a data read returns 0x01, `irq_n` is high and `midi_tx` is high.
- R2: Each transmitted frame is one low start bit, then data bits 0 to 7, then one high stop bit. Every bit lasts CLKS_PER_BIT clocks. The line is high whenever no frame is being sent.
- R3: A data write clears transmit-empty (status bit 1) on the same clock edge. If no frame was in flight, the start bit begins at that edge and transmit-empty sets again CLKS_PER_BIT clocks after the write.
- R4: A data write made while a frame is in flight is held until that frame ends. Its start bit follows the previous stop bit with no gap, and transmit-empty sets CLKS_PER_BIT clocks after that frame boundary.
- R5: The receiver samples the line CLKS_PER_BIT/2 clocks after a falling edge, and then once every CLKS_PER_BIT clocks. After the stop-bit sample it loads the byte into the receive register and sets receive-full (status bit 0). A new byte replaces an unread one.
- R6: If the line is high at the start-bit sample, the frame is dropped. Receive-full and the receive register stay unchanged.
- R7: A read of the data location returns the receive register and clears receive-full, unless a byte arrives on the same edge.
- R8: A status read returns bit 7 = interrupt pending, bit 1 = transmit-empty, bit 0 = receive-full. All other bits read 0.
- R9: A receive interrupt is pending when control bit 7 is 1 and receive-full is set.
- R10: A transmit interrupt is pending only when control bits 6:5 equal 01 and transmit-empty is set. The patterns 00, 10 and 11 never raise it.
- R11: `irq_n` is low exactly while a receive or transmit cause is pending. It changes on the same edge as the control or status change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel_data | input | 1 | 0 selects status/control, 1 selects receive/transmit data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; result appears after the edge |
| bus_wdata | input | DATA_BITS | Write data |
| bus_rdata | output | DATA_BITS | Registered read data |
| midi_rx | input | 1 | Serial receive line |
| midi_tx | output | 1 | Serial transmit line, idle high |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
On every cycle, the checker confirms four things: the interrupt line matches the enable patterns and the flags, a data write always leaves transmit-empty clear, transmit-empty only rises while a frame is on the line, and the line sits high whenever the shifter is idle. It also confirms that a finished reception always sets receive-full and that a data read clears it. The bench's scenarios are the only place that shows exact timing: the 256-clock set point of transmit-empty after an idle write, the delay that follows a write made during a frame, the seamless start of the next frame, mid-bit sampling with overwrite and false-start rejection, and a byte looped from the transmitter back into the receiver.

// File: rtl/midi_port_pkg.sv
package midi_port_pkg;
  // Status byte layout; software decodes these positions.
  localparam int STAT_IRQ_BIT  = 7;
  localparam int STAT_TXE_BIT  = 1;
  localparam int STAT_RXF_BIT  = 0;
  // Control byte enable decoding.
  localparam int CTRL_RXIE_BIT = 7;
  localparam int CTRL_TXM_HI   = 6;
  localparam int CTRL_TXM_LO   = 5;
  localparam logic [1:0] TX_IRQ_MODE = 2'b01;
  // Receive data register contents after reset.
  localparam logic [7:0] RXDATA_RESET = 8'h01;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/midi_irq_decode.sv
module midi_irq_decode
  import midi_port_pkg::*;
(
  input  logic       rx_enable,
  input  logic [1:0] tx_mode,
  input  logic       rx_full,
  input  logic       tx_empty,
  output logic       irq_req
);
  logic rx_cause;
  logic tx_cause;

  always_comb begin
    rx_cause = rx_enable && rx_full;
    tx_cause = (tx_mode == TX_IRQ_MODE) && tx_empty;
    irq_req  = rx_cause || tx_cause;
  end
endmodule

// File: rtl/midi_tx_serializer.sv
module midi_tx_serializer #(
  parameter int CLKS_PER_BIT = 256,
  parameter int DATA_BITS    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_stb,
  input  logic [DATA_BITS-1:0] wr_byte,
  output logic                 tx_line,
  output logic                 busy,
  output logic                 tx_empty,
  output logic                 tx_empty_nxt
);
  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int IW = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] CNT_LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(FRAME_BITS - 1);

  logic [CW-1:0]         clk_cnt;
  logic [IW-1:0]         bit_idx;
  logic [FRAME_BITS-1:0] frame_sr;
  logic [DATA_BITS-1:0]  hold_q;
  logic                  hold_full;

  logic bit_end;
  logic frame_end;
  logic start_end;
  logic load_from_hold;
  logic load_direct;

  always_comb begin
    bit_end        = busy && (clk_cnt == CNT_LAST);
    frame_end      = bit_end && (bit_idx == IDX_LAST);
    start_end      = bit_end && (bit_idx == '0);
    load_from_hold = frame_end && hold_full;
    load_direct    = wr_stb && !hold_full && (!busy || frame_end);
    if (wr_stb)
      tx_empty_nxt = 1'b0;
    else if (start_end && !hold_full)
      tx_empty_nxt = 1'b1;
    else
      tx_empty_nxt = tx_empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_cnt   <= '0;
      bit_idx   <= '0;
      frame_sr  <= '1;
      hold_q    <= '0;
      hold_full <= 1'b0;
      busy      <= 1'b0;
      tx_line   <= 1'b1;
      tx_empty  <= 1'b1;
    end else begin
      tx_empty <= tx_empty_nxt;
      if (load_from_hold || load_direct) begin
        frame_sr <= {1'b1, (load_from_hold ? hold_q : wr_byte), 1'b0};
        busy     <= 1'b1;
        clk_cnt  <= '0;
        bit_idx  <= '0;
        tx_line  <= 1'b0;
      end else if (frame_end) begin
        busy    <= 1'b0;
        clk_cnt <= '0;
        bit_idx <= '0;
        tx_line <= 1'b1;
      end else if (bit_end) begin
        clk_cnt  <= '0;
        bit_idx  <= bit_idx + IW'(1);
        tx_line  <= frame_sr[1];
        frame_sr <= {1'b1, frame_sr[FRAME_BITS-1:1]};
      end else if (busy) begin
        clk_cnt <= clk_cnt + CW'(1);
      end

      if (wr_stb && !load_direct) begin
        hold_q    <= wr_byte;
        hold_full <= 1'b1;
      end else if (load_from_hold) begin
        hold_full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/midi_rx_deframer.sv
module midi_rx_deframer
  import midi_port_pkg::*;
#(
  parameter int CLKS_PER_BIT = 256,
  parameter int DATA_BITS    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_line,
  output logic                 rx_done,
  output logic [DATA_BITS-1:0] rx_byte
);
  localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int BW = $clog2(DATA_BITS + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] CNT_MID  = CW'(CLKS_PER_BIT / 2 - 1);
  localparam logic [BW-1:0] STOP_IDX = BW'(DATA_BITS);

  rx_state_e            state;
  logic                 sync1;
  logic                 sync2;
  logic                 prev;
  logic [CW-1:0]        cnt;
  logic [BW-1:0]        bitn;
  logic [DATA_BITS-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      sync1   <= 1'b1;
      sync2   <= 1'b1;
      prev    <= 1'b1;
      cnt     <= '0;
      bitn    <= '0;
      shreg   <= '0;
      rx_done <= 1'b0;
      rx_byte <= '0;
    end else begin
      sync1   <= rx_line;
      sync2   <= sync1;
      prev    <= sync2;
      rx_done <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          if (prev && !sync2) begin
            state <= RX_START;
            cnt   <= '0;
          end
        end
        RX_START: begin
          if (cnt == CNT_MID) begin
            cnt  <= '0;
            bitn <= '0;
            state <= sync2 ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        RX_DATA: begin
          if (cnt == CNT_LAST) begin
            cnt <= '0;
            if (bitn == STOP_IDX) begin
              rx_done <= 1'b1;
              rx_byte <= shreg;
              state   <= RX_IDLE;
            end else begin
              shreg <= {sync2, shreg[DATA_BITS-1:1]};
              bitn  <= bitn + BW'(1);
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/midi_serial_port.sv
module midi_serial_port
  import midi_port_pkg::*;
#(
  parameter int CLKS_PER_BIT = 256,
  parameter int DATA_BITS    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel_data,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [DATA_BITS-1:0] bus_wdata,
  output logic [DATA_BITS-1:0] bus_rdata,
  input  logic                 midi_rx,
  output logic                 midi_tx,
  output logic                 irq_n
);
  logic [DATA_BITS-1:0] ctrl_q;
  logic [DATA_BITS-1:0] ctrl_nxt;
  logic [DATA_BITS-1:0] rxdata_q;
  logic [DATA_BITS-1:0] status_w;
  logic                 rxf_q;
  logic                 rxf_nxt;
  logic                 irq_q;
  logic                 irq_nxt;
  logic                 tdre_q;
  logic                 tdre_nxt;
  logic                 tx_busy;
  logic                 rx_done;
  logic [DATA_BITS-1:0] rx_byte;

  logic wr_ctrl, wr_data, rd_stat, rd_data;

  always_comb begin
    wr_ctrl  = bus_wr && !bus_sel_data;
    wr_data  = bus_wr &&  bus_sel_data;
    rd_stat  = bus_rd && !bus_sel_data;
    rd_data  = bus_rd &&  bus_sel_data;
    ctrl_nxt = wr_ctrl ? bus_wdata : ctrl_q;
    if (rx_done)      rxf_nxt = 1'b1;
    else if (rd_data) rxf_nxt = 1'b0;
    else              rxf_nxt = rxf_q;
    status_w                = '0;
    status_w[STAT_IRQ_BIT]  = irq_q;
    status_w[STAT_TXE_BIT]  = tdre_q;
    status_w[STAT_RXF_BIT]  = rxf_q;
  end

  midi_tx_serializer #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .DATA_BITS   (DATA_BITS)
  ) u_tx (
    .clk         (clk),
    .rst         (rst),
    .wr_stb      (wr_data),
    .wr_byte     (bus_wdata),
    .tx_line     (midi_tx),
    .busy        (tx_busy),
    .tx_empty    (tdre_q),
    .tx_empty_nxt(tdre_nxt)
  );

  midi_rx_deframer #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .DATA_BITS   (DATA_BITS)
  ) u_rx (
    .clk    (clk),
    .rst    (rst),
    .rx_line(midi_rx),
    .rx_done(rx_done),
    .rx_byte(rx_byte)
  );

  // Interrupt decided from next-state values so it moves with the flags.
  midi_irq_decode u_irq (
    .rx_enable(ctrl_nxt[CTRL_RXIE_BIT]),
    .tx_mode  (ctrl_nxt[CTRL_TXM_HI:CTRL_TXM_LO]),
    .rx_full  (rxf_nxt),
    .tx_empty (tdre_nxt),
    .irq_req  (irq_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      rxdata_q  <= DATA_BITS'(RXDATA_RESET);
      rxf_q     <= 1'b0;
      irq_q     <= 1'b0;
      bus_rdata <= '0;
    end else begin
      ctrl_q <= ctrl_nxt;
      rxf_q  <= rxf_nxt;
      irq_q  <= irq_nxt;
      if (rx_done) rxdata_q <= rx_byte;
      if (rd_stat)      bus_rdata <= status_w;
      else if (rd_data) bus_rdata <= rxdata_q;
    end
  end

  assign irq_n = !irq_q;
endmodule

// File: rtl/midi_serial_port_chk.sv
module midi_serial_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_sel_data,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       midi_tx,
  input logic       irq_n,
  input logic [7:0] ctrl_q,
  input logic       rxf_q,
  input logic       tdre_q,
  input logic       tx_busy,
  input logic       rx_done
);
  // R11 / R9 / R10: interrupt line against the flags and enable patterns
  assert_irq_level_R11: assert property (@(posedge clk) disable iff (rst)
    (!irq_n) == ((ctrl_q[7] && rxf_q) || (ctrl_q[6:5] == 2'b01 && tdre_q)));

  assert_write_clears_empty_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_sel_data) |=> !tdre_q);

  assert_empty_rises_in_frame_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(tdre_q) |-> tx_busy);

  assert_idle_line_high_R2: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> midi_tx);

  assert_done_sets_full_R5: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> rxf_q);

  assert_read_clears_full_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_sel_data && !rx_done) |=> !rxf_q);
endmodule

bind midi_serial_port midi_serial_port_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_sel_data(bus_sel_data),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .midi_tx     (midi_tx),
  .irq_n       (irq_n),
  .ctrl_q      (ctrl_q[7:0]),
  .rxf_q       (rxf_q),
  .tdre_q      (tdre_q),
  .tx_busy     (tx_busy),
  .rx_done     (rx_done)
);

// File: tb/midi_serial_port_bench.sv
module midi_serial_port_bench;
  localparam int CPB   = 256;
  localparam int HALF  = CPB / 2;
  localparam int FRAME = CPB * 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel_data = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic bench_rx = 1'b1, loop_en = 1'b0;
  logic midi_rx, midi_tx, irq_n;

  assign midi_rx = loop_en ? midi_tx : bench_rx;

  always #5 clk = ~clk;

  midi_serial_port u_midi_serial_port (
    .clk(clk), .rst(rst), .bus_sel_data(bus_sel_data), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .midi_rx(midi_rx), .midi_tx(midi_tx), .irq_n(irq_n));

  int vectors = 0, fails = 0, cyc = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  // ---------------- behavioural reference model ----------------
  int t, cur_start, empty_at, r_start, r_i, ld_at, idx;
  bit tx_act, nxt_v, r_act, r_prev, rx_v;
  logic [7:0] cur_byte, nxt_b, r_sh, ld_b;
  logic [7:0] m_ctrl, m_rxdata, m_rdata;
  bit m_rxf, m_tdre, m_irq, m_tx;

  always @(posedge clk) begin
    if (rst) begin
      t = 0; m_ctrl = 0; m_rxf = 0; m_tdre = 1; m_rxdata = 8'h01; m_rdata = 0;
      m_irq = 0; m_tx = 1; tx_act = 0; nxt_v = 0; empty_at = -1;
      r_act = 0; r_prev = 1; ld_at = -1;
    end else begin
      t++;
      rx_v = loop_en ? m_tx : bench_rx;
      if (bus_rd) m_rdata = bus_sel_data ? m_rxdata : {m_irq, 5'b0, m_tdre, m_rxf};
      if (bus_wr && !bus_sel_data) m_ctrl = bus_wdata;
      if (tx_act && t == cur_start + FRAME) begin
        if (nxt_v) begin cur_start = t; cur_byte = nxt_b; nxt_v = 0; end
        else tx_act = 0;
      end
      if (bus_wr && bus_sel_data) begin
        if (!tx_act) begin
          tx_act = 1; cur_start = t; cur_byte = bus_wdata; empty_at = t + CPB;
        end else begin
          nxt_v = 1; nxt_b = bus_wdata; empty_at = cur_start + FRAME + CPB;
        end
        m_tdre = 0;
      end else if (!m_tdre && t == empty_at) m_tdre = 1;
      if (tx_act) begin
        idx = (t - cur_start) / CPB;
        m_tx = (idx == 0) ? 1'b0 : (idx <= 8) ? cur_byte[idx-1] : 1'b1;
      end else m_tx = 1;
      if (!r_act) begin
        if (r_prev && !rx_v) begin r_act = 1; r_start = t; r_i = 0; end
      end else if (t == r_start + HALF + CPB * r_i) begin
        if (r_i == 0) begin if (rx_v) r_act = 0; else r_i = 1; end
        else if (r_i <= 8) begin r_sh[r_i-1] = rx_v; r_i++; end
        else begin ld_at = t + 3; ld_b = r_sh; r_act = 0; end
      end
      r_prev = rx_v;
      if (t == ld_at) begin m_rxdata = ld_b; m_rxf = 1; end
      else if (bus_rd && bus_sel_data) m_rxf = 0;
      m_irq = (m_ctrl[7] && m_rxf) || (m_ctrl[6:5] == 2'b01 && m_tdre);
    end
  end

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(midi_tx === m_tx, "R2 midi_tx vs model", int'(midi_tx), int'(m_tx));
      check(irq_n === !m_irq, "R11 irq_n vs model", int'(irq_n), int'(!m_irq));
      check(bus_rdata === m_rdata, "R8 bus_rdata vs model", int'(bus_rdata), int'(m_rdata));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic bus_write(input logic sel, input logic [7:0] d);
    bus_sel_data = sel; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic sel, output logic [7:0] d);
    bus_sel_data = sel; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic send_rx(input logic [7:0] b);
    bench_rx = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      bench_rx = b[i];
      repeat (CPB) @(negedge clk);
    end
    bench_rx = 1'b1;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finish_run();
  end

  // ---------------- directed scenarios ----------------
  initial begin
    logic [7:0] rd;
    int w1, w2;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 / R8: reset state
    check(irq_n === 1'b1, "R1 irq_n after reset", int'(irq_n), 1);
    check(midi_tx === 1'b1, "R1 midi_tx idle after reset", int'(midi_tx), 1);
    bus_read(1'b0, rd); check(rd === 8'h02, "R1 status after reset", int'(rd), 8'h02);
    bus_read(1'b1, rd); check(rd === 8'h01, "R1 data register after reset", int'(rd), 8'h01);

    // R10: tx interrupt with transmit-empty already set
    bus_write(1'b0, 8'h20);
    check(irq_n === 1'b0, "R10 ctrl 01 pattern with empty", int'(irq_n), 0);

    // R3: idle write, transmit-empty back after one bit
    bus_write(1'b1, 8'hA5);
    w1 = cyc;
    check(irq_n === 1'b1, "R3 empty cleared by write", int'(irq_n), 1);
    while (irq_n === 1'b1 && cyc < w1 + 400) @(negedge clk);
    check(cyc == w1 + CPB, "R3 empty set time after idle write", cyc - w1, CPB);

    // R4: write while frame in flight
    bus_write(1'b1, 8'h3C);
    w2 = cyc;
    while (cyc < w1 + FRAME - 1) @(negedge clk);
    check(midi_tx === 1'b1, "R4 stop bit of first frame", int'(midi_tx), 1);
    @(negedge clk);
    check(midi_tx === 1'b0, "R4 second start bit without gap", int'(midi_tx), 0);
    check(irq_n === 1'b1, "R4 empty still clear at frame boundary", int'(irq_n), 1);
    while (irq_n === 1'b1 && cyc < w1 + FRAME + 400) @(negedge clk);
    check(cyc == w1 + FRAME + CPB, "R4 empty set time after queued write",
          cyc - w2, w1 + FRAME + CPB - w2);
    while (cyc < w1 + 2 * FRAME + 4) @(negedge clk);
    check(midi_tx === 1'b1, "R2 line idle after both frames", int'(midi_tx), 1);

    // R10: other tx patterns give no interrupt
    bus_write(1'b0, 8'h40); check(irq_n === 1'b1, "R10 ctrl 10 pattern", int'(irq_n), 1);
    bus_write(1'b0, 8'h60); check(irq_n === 1'b1, "R10 ctrl 11 pattern", int'(irq_n), 1);
    bus_write(1'b0, 8'h00); check(irq_n === 1'b1, "R10 ctrl 00 pattern", int'(irq_n), 1);
    bus_write(1'b0, 8'h80); check(irq_n === 1'b1, "R9 rx enable without data", int'(irq_n), 1);

    // R5 / R9 / R8 / R7: reception
    send_rx(8'h96);
    repeat (4) @(negedge clk);
    check(irq_n === 1'b0, "R9 rx interrupt", int'(irq_n), 0);
    bus_read(1'b0, rd); check(rd === 8'h83, "R8 status with rx full", int'(rd), 8'h83);
    bus_read(1'b1, rd); check(rd === 8'h96, "R5 received byte", int'(rd), 8'h96);
    bus_read(1'b0, rd); check(rd === 8'h02, "R7 rx full cleared by read", int'(rd), 8'h02);
    check(irq_n === 1'b1, "R11 irq released after read", int'(irq_n), 1);

    // R5 overwrite
    send_rx(8'h11);
    send_rx(8'hE7);
    repeat (4) @(negedge clk);
    bus_read(1'b1, rd); check(rd === 8'hE7, "R5 newer byte replaces unread", int'(rd), 8'hE7);

    // R6: false start
    bench_rx = 1'b0; repeat (60) @(negedge clk); bench_rx = 1'b1;
    repeat (FRAME + 400) @(negedge clk);
    bus_read(1'b0, rd); check(rd === 8'h02, "R6 false start leaves rx empty", int'(rd), 8'h02);
    bus_read(1'b1, rd); check(rd === 8'hE7, "R6 false start keeps data register", int'(rd), 8'hE7);

    // R2 / R5: loopback
    loop_en = 1'b1;
    repeat (4) @(negedge clk);
    bus_write(1'b1, 8'h5A);
    repeat (FRAME + 20) @(negedge clk);
    bus_read(1'b0, rd); check(rd === 8'h83, "R8 status after loopback", int'(rd), 8'h83);
    bus_read(1'b1, rd); check(rd === 8'h5A, "R2 looped back byte", int'(rd), 8'h5A);

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule